// File: doc/BRIEF.md
# OSD Pixel Layer Compositor

This block merges three on-screen-display pixel sources into one pixel per transfer: a cursor plane, a graphics plane and a text plane. Each plane delivers a 4-bit colour code together with a palette index. The block removes planes that are switched off or whose pixel is see-through, picks the topmost remaining plane, and emits the chosen code and palette index. It also emits a keying signal (YS), which says that the on-screen picture covers the video, and a translucency signal (YM), which says that the video should be mixed under it.

Pixels enter as one bundle on a valid/ready stream and leave on a second valid/ready stream after one register stage. A bundle is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle, so a downstream stall pushes straight back to the source with no extra buffering. While `out_valid` is high and `out_ready` is low, every output holds its value. Control settings come from a 15-bit register written through a single write strobe.

Top module: `osd_layer_mixer`

## Requirements
- R1: A bundle accepted at a clock edge appears on the outputs with `out_valid` high after that same edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_code`, `out_pal`, `out_ys` and `out_ym` hold their values.
- R2: A cycle with `cfg_wr` high loads `cfg_wdata` into the control register. Reset clears the control register and clears `out_valid` and all output data to 0. The control fields are: bit0 cursor enable, bit1 graphics enable, bit2 text enable, bit3 text-over-graphics, bit4 keep colour 0, bit5 keep colour 15, bit6 YS hold, bit7 split mode, bits[9:8] graphics depth, bit10 background enable, bits[14:11] background code.
- R3: A plane whose enable bit is 0 never supplies the output, whatever its code.
- R4: A visible cursor pixel always wins. Between graphics and text, graphics wins when bit3 is 0 and text wins when bit3 is 1.
- R5: With keep colour 0 at 0 and split mode off, code 0 on any plane is invisible and the next plane down shows. With keep colour 0 at 1, code 0 is a visible colour.
- R6: With keep colour 15 at 0 and split mode off, a winning code 15 is output with `out_ym` high. In every other case `out_ym` is low.
- R7: With YS hold at 1 and split mode off, `out_ys` is low while `out_ym` is high. Otherwise a visible winning pixel drives `out_ys` high.
- R8: With split mode at 1, YS hold has no effect, and colour 0 and colour 15 are treated as ordinary visible colours.
- R9: Depth field 00, 01, 10 and 11 masks the graphics code to its low 4, 3, 2 and 1 bits. The masked value is used both for visibility and as the output code.
- R10: If no plane is visible and background enable is 1, the output is the background code with palette index 0, `out_ys` high and `out_ym` low. If background enable is 0, the output is code 0, palette 0, with `out_ys` and `out_ym` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 15 | Control register write data |
| in_valid | input | 1 | Input pixel bundle valid |
| in_ready | output | 1 | Input pixel bundle may be taken |
| cur_code | input | 4 | Cursor colour code |
| cur_pal | input | PAL_W | Cursor palette index |
| gfx_code | input | 4 | Graphics colour code, before depth masking |
| gfx_pal | input | PAL_W | Graphics palette index |
| txt_code | input | 4 | Text colour code |
| txt_pal | input | PAL_W | Text palette index |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream takes the output pixel |
| out_code | output | 4 | Selected colour code |
| out_pal | output | PAL_W | Selected palette index |
| out_ys | output | 1 | Picture keying signal |
| out_ym | output | 1 | Translucency signal |

## Verification
The checker compares each output pixel with the control register as it stands in that cycle. It therefore assumes that the register is written only while no pixel is held in the output stage. The bench keeps to this rule. It writes the register only after the output stage has drained, with `in_valid` low. The stall properties assume only that the source holds a bundle steady until it is taken. The bench drives each bundle for exactly the one cycle in which `in_ready` is high. It applies random downstream stalls only after the bundle has been accepted.

// File: rtl/osd_mix_pkg.sv
package osd_mix_pkg;

  localparam int CODE_W  = 4;
  localparam int NLAYER  = 3;
  localparam int CFG_W   = 15;

  localparam int L_CUR = 0;
  localparam int L_GFX = 1;
  localparam int L_TXT = 2;

  typedef struct packed {
    logic [CODE_W-1:0] bg_code;
    logic              bg_en;
    logic [1:0]        gfx_depth;
    logic              split;
    logic              ys_hold;
    logic              keep_c15;
    logic              keep_c0;
    logic              text_first;
    logic              txt_en;
    logic              gfx_en;
    logic              cur_en;
  } mix_cfg_t;

  function automatic logic [CODE_W-1:0] depth_mask(input logic [1:0] depth);
    logic [CODE_W-1:0] m;
    m = '1;
    m = m >> depth;
    return m;
  endfunction

endpackage

// File: rtl/osd_cfg_reg.sv
module osd_cfg_reg
  import osd_mix_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  output mix_cfg_t         cfg
);

  mix_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr) begin
      cfg_q.cur_en     <= wdata[0];
      cfg_q.gfx_en     <= wdata[1];
      cfg_q.txt_en     <= wdata[2];
      cfg_q.text_first <= wdata[3];
      cfg_q.keep_c0    <= wdata[4];
      cfg_q.keep_c15   <= wdata[5];
      cfg_q.ys_hold    <= wdata[6];
      cfg_q.split      <= wdata[7];
      cfg_q.gfx_depth  <= wdata[9:8];
      cfg_q.bg_en      <= wdata[10];
      cfg_q.bg_code    <= wdata[14:11];
    end
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/osd_layer_qual.sv
module osd_layer_qual
  import osd_mix_pkg::*;
(
  input  logic              en,
  input  logic              keep_zero,
  input  logic [CODE_W-1:0] mask,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_out,
  output logic              visible
);

  logic [CODE_W-1:0] masked;

  always_comb begin
    masked   = code_in & mask;
    code_out = masked;
    visible  = en && ((masked != '0) || keep_zero);
  end

endmodule

// File: rtl/osd_prio_sel.sv
module osd_prio_sel
  import osd_mix_pkg::*;
#(
  parameter int PAL_W = 3
)(
  input  logic [NLAYER-1:0]             vis,
  input  logic [NLAYER-1:0][CODE_W-1:0] code,
  input  logic [NLAYER-1:0][PAL_W-1:0]  pal,
  input  logic                          text_first,
  input  logic                          keep_c15,
  input  logic                          ys_hold,
  input  logic                          bg_en,
  input  logic [CODE_W-1:0]             bg_code,
  output logic [CODE_W-1:0]             sel_code,
  output logic [PAL_W-1:0]              sel_pal,
  output logic                          sel_ys,
  output logic                          sel_ym
);

  localparam logic [CODE_W-1:0] TRANSLUCENT = '1;

  logic [1:0]        upper;
  logic [1:0]        lower;
  logic              hit;
  logic [CODE_W-1:0] win_code;
  logic [PAL_W-1:0]  win_pal;

  always_comb begin
    upper = text_first ? 2'(L_TXT) : 2'(L_GFX);
    lower = text_first ? 2'(L_GFX) : 2'(L_TXT);
  end

  always_comb begin
    hit      = 1'b1;
    win_code = '0;
    win_pal  = '0;
    if (vis[L_CUR]) begin
      win_code = code[L_CUR];
      win_pal  = pal[L_CUR];
    end else if (vis[upper]) begin
      win_code = code[upper];
      win_pal  = pal[upper];
    end else if (vis[lower]) begin
      win_code = code[lower];
      win_pal  = pal[lower];
    end else begin
      hit = 1'b0;
    end
  end

  always_comb begin
    sel_code = '0;
    sel_pal  = '0;
    sel_ys   = 1'b0;
    sel_ym   = 1'b0;
    if (hit) begin
      sel_code = win_code;
      sel_pal  = win_pal;
      sel_ym   = (win_code == TRANSLUCENT) && !keep_c15;
      sel_ys   = !(ys_hold && sel_ym && (win_code != '0));
    end else if (bg_en) begin
      sel_code = bg_code;
      sel_ys   = 1'b1;
    end
  end

endmodule

// File: rtl/osd_out_stage.sv
module osd_out_stage #(
  parameter int DATA_W = 9
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              take;

  assign in_ready = !full_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (take) begin
        full_q <= 1'b1;
        data_q <= in_data;
      end else if (out_ready) begin
        full_q <= 1'b0;
      end
    end
  end

  assign out_valid = full_q;
  assign out_data  = data_q;

endmodule

// File: rtl/osd_layer_mixer.sv
module osd_layer_mixer
  import osd_mix_pkg::*;
#(
  parameter int PAL_W = 3
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] cur_code,
  input  logic [PAL_W-1:0]  cur_pal,
  input  logic [CODE_W-1:0] gfx_code,
  input  logic [PAL_W-1:0]  gfx_pal,
  input  logic [CODE_W-1:0] txt_code,
  input  logic [PAL_W-1:0]  txt_pal,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CODE_W-1:0] out_code,
  output logic [PAL_W-1:0]  out_pal,
  output logic              out_ys,
  output logic              out_ym
);

  localparam int PIX_W = CODE_W + PAL_W + 2;

  mix_cfg_t cfg_q;

  osd_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .cfg   (cfg_q)
  );

  // split mode forces both special colours to behave as ordinary ones
  logic keep_c0_eff;
  logic keep_c15_eff;
  logic hold_eff;

  assign keep_c0_eff  = cfg_q.keep_c0  || cfg_q.split;
  assign keep_c15_eff = cfg_q.keep_c15 || cfg_q.split;
  assign hold_eff     = cfg_q.ys_hold  && !cfg_q.split;

  logic [NLAYER-1:0]             lay_en;
  logic [NLAYER-1:0][CODE_W-1:0] lay_raw;
  logic [NLAYER-1:0][CODE_W-1:0] lay_mask;
  logic [NLAYER-1:0][CODE_W-1:0] lay_code;
  logic [NLAYER-1:0][PAL_W-1:0]  lay_pal;
  logic [NLAYER-1:0]             lay_vis;

  assign lay_en   = {cfg_q.txt_en, cfg_q.gfx_en, cfg_q.cur_en};
  assign lay_raw  = {txt_code, gfx_code, cur_code};
  assign lay_pal  = {txt_pal, gfx_pal, cur_pal};

  genvar gi;
  generate
    for (gi = 0; gi < NLAYER; gi++) begin : g_layer
      if (gi == L_GFX) begin : g_depth
        assign lay_mask[gi] = depth_mask(cfg_q.gfx_depth);
      end else begin : g_full
        assign lay_mask[gi] = '1;
      end

      osd_layer_qual u_qual (
        .en        (lay_en[gi]),
        .keep_zero (keep_c0_eff),
        .mask      (lay_mask[gi]),
        .code_in   (lay_raw[gi]),
        .code_out  (lay_code[gi]),
        .visible   (lay_vis[gi])
      );
    end
  endgenerate

  logic [CODE_W-1:0] sel_code;
  logic [PAL_W-1:0]  sel_pal;
  logic              sel_ys;
  logic              sel_ym;

  osd_prio_sel #(.PAL_W(PAL_W)) u_sel (
    .vis        (lay_vis),
    .code       (lay_code),
    .pal        (lay_pal),
    .text_first (cfg_q.text_first),
    .keep_c15   (keep_c15_eff),
    .ys_hold    (hold_eff),
    .bg_en      (cfg_q.bg_en),
    .bg_code    (cfg_q.bg_code),
    .sel_code   (sel_code),
    .sel_pal    (sel_pal),
    .sel_ys     (sel_ys),
    .sel_ym     (sel_ym)
  );

  logic [PIX_W-1:0] pix_d;
  logic [PIX_W-1:0] pix_q;

  assign pix_d = {sel_code, sel_pal, sel_ys, sel_ym};

  osd_out_stage #(.DATA_W(PIX_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pix_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pix_q)
  );

  assign {out_code, out_pal, out_ys, out_ym} = pix_q;

endmodule

// File: rtl/osd_mix_chk.sv
module osd_mix_chk #(
  parameter int PAL_W = 3
)(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [3:0]       out_code,
  input logic [PAL_W-1:0] out_pal,
  input logic             out_ys,
  input logic             out_ym,
  input logic             split,
  input logic             ys_hold,
  input logic             bg_en
);

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);  // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_code) && $stable(out_pal)
      && $stable(out_ys) && $stable(out_ym));  // R1

  AST_YM_ONLY_15: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ym |-> out_code == 4'hF);  // R6

  AST_YS_WITHHELD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ym && ys_hold && !split |-> !out_ys);  // R7

  AST_SPLIT_NO_YM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && split |-> !out_ym);  // R8

  AST_DARK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ys && !out_ym |-> out_code == 4'h0 && out_pal == '0 && !bg_en);  // R10

endmodule

bind osd_layer_mixer osd_mix_chk #(.PAL_W(PAL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_code  (out_code),
  .out_pal   (out_pal),
  .out_ys    (out_ys),
  .out_ym    (out_ym),
  .split     (cfg_q.split),
  .ys_hold   (cfg_q.ys_hold),
  .bg_en     (cfg_q.bg_en)
);

// File: tb/test_osd_layer_mixer.sv
module test_osd_layer_mixer;

  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [14:0]   cfg_wdata = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [3:0]    cur_code = '0, gfx_code = '0, txt_code = '0;
  logic [PW-1:0] cur_pal = '0, gfx_pal = '0, txt_pal = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [3:0]    out_code;
  logic [PW-1:0] out_pal;
  logic          out_ys, out_ym;

  int checks = 0;
  int errors = 0;
  logic [14:0] cfg_now = '0;

  always #2 clk = ~clk;

  osd_layer_mixer #(.PAL_W(PW)) i_osd_layer_mixer (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready),
    .cur_code(cur_code), .cur_pal(cur_pal),
    .gfx_code(gfx_code), .gfx_pal(gfx_pal),
    .txt_code(txt_code), .txt_pal(txt_pal),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_code(out_code), .out_pal(out_pal), .out_ys(out_ys), .out_ym(out_ym)
  );

  function automatic logic [14:0] mk(input bit ce, ge, te, tf, k0, k15, hold, sp,
                                      input bit [1:0] dep, input bit bge, input bit [3:0] bgc);
    return {bgc, bge, dep, sp, hold, k15, k0, tf, te, ge, ce};
  endfunction

  // expected {code, pal, ys, ym}
  function automatic logic [4+PW+1:0] model(input logic [14:0] c,
      input logic [3:0] cc, input logic [PW-1:0] cp,
      input logic [3:0] gc, input logic [PW-1:0] gp,
      input logic [3:0] tc, input logic [PW-1:0] tp);
    bit sp, zero_ok, c15_ok, hold, vc, vg, vt, got;
    logic [3:0] g, wc;
    logic [PW-1:0] wp;
    sp = c[7];
    zero_ok = c[4] | sp;
    c15_ok  = c[5] | sp;
    hold    = c[6] & ~sp;
    case (c[9:8])
      2'd0: g = gc;
      2'd1: g = {1'b0, gc[2:0]};
      2'd2: g = {2'b00, gc[1:0]};
      default: g = {3'b000, gc[0]};
    endcase
    vc = c[0] && (cc != 0 || zero_ok);
    vg = c[1] && (g  != 0 || zero_ok);
    vt = c[2] && (tc != 0 || zero_ok);
    got = 1; wc = 0; wp = 0;
    if (vc) begin wc = cc; wp = cp; end
    else if (c[3] && vt) begin wc = tc; wp = tp; end
    else if (vg) begin wc = g; wp = gp; end
    else if (vt) begin wc = tc; wp = tp; end
    else got = 0;
    if (got) begin
      bit ym;
      ym = (wc == 4'hF) && !c15_ok;
      return {wc, wp, !(ym && hold), ym};
    end
    if (c[10]) return {c[14:11], {PW{1'b0}}, 1'b1, 1'b0};
    return '0;
  endfunction

  task automatic wcfg(input logic [14:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
    cfg_now = v;
  endtask

  task automatic pix(input logic [3:0] cc, input logic [PW-1:0] cp,
                     input logic [3:0] gc, input logic [PW-1:0] gp,
                     input logic [3:0] tc, input logic [PW-1:0] tp,
                     input int stall, input string req);
    logic [4+PW+1:0] exp_v, act;
    exp_v = model(cfg_now, cc, cp, gc, gp, tc, tp);
    @(negedge clk);
    cur_code = cc; cur_pal = cp; gfx_code = gc; gfx_pal = gp;
    txt_code = tc; txt_pal = tp; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    act = {out_code, out_pal, out_ys, out_ym};
    checks++;
    if (!out_valid || act !== exp_v) begin
      errors++;
      $display("FAIL %s: valid=%b code/pal/ys/ym=%h expected valid=1 %h", req, out_valid, act, exp_v);
    end
    if (stall > 0) begin
      out_ready = 1'b0;
      for (int k = 0; k < stall; k++) begin
        @(negedge clk);
        act = {out_code, out_pal, out_ys, out_ym};
        checks++;
        if (!out_valid || in_ready || act !== exp_v) begin
          errors++;
          $display("FAIL R1 stall: valid=%b ready=%b data=%h expected valid=1 ready=0 %h",
                   out_valid, in_ready, act, exp_v);
        end
      end
      out_ready = 1'b1;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // reset state, R2
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1 || {out_code, out_pal, out_ys, out_ym} !== '0) begin
      errors++;
      $display("FAIL R2 reset: valid=%b ready=%b data=%h expected 0 1 0", out_valid, in_ready,
               {out_code, out_pal, out_ys, out_ym});
    end
    rst_n = 1'b1;
    // R2: control cleared by reset -> all planes off, dark output
    pix(4'h3, 3'd1, 4'h4, 3'd2, 4'h6, 3'd3, 0, "R2");

    // R3 enables
    wcfg(mk(0,1,0,0,0,0,0,0,2'd0,0,4'h0));
    pix(4'h3, 3'd1, 4'h5, 3'd2, 4'h6, 3'd3, 0, "R3");
    wcfg(mk(0,0,0,0,1,0,0,0,2'd0,0,4'h0));
    pix(4'h3, 3'd1, 4'h5, 3'd2, 4'h6, 3'd3, 0, "R3");

    // R4 priority
    wcfg(mk(1,1,1,0,0,0,0,0,2'd0,0,4'h0));
    pix(4'h3, 3'd1, 4'h4, 3'd2, 4'h6, 3'd3, 2, "R4");
    pix(4'h0, 3'd1, 4'h4, 3'd2, 4'h6, 3'd3, 0, "R4");
    wcfg(mk(1,1,1,1,0,0,0,0,2'd0,0,4'h0));
    pix(4'h0, 3'd1, 4'h4, 3'd2, 4'h6, 3'd3, 0, "R4");
    pix(4'h9, 3'd5, 4'h4, 3'd2, 4'h6, 3'd3, 3, "R4");

    // R5 colour 0
    wcfg(mk(0,1,1,0,0,1,0,0,2'd0,0,4'h0));
    pix(4'h0, 3'd0, 4'h0, 3'd2, 4'h7, 3'd4, 0, "R5");
    wcfg(mk(0,1,1,0,1,1,0,0,2'd0,0,4'h0));
    pix(4'h0, 3'd0, 4'h0, 3'd2, 4'h7, 3'd4, 0, "R5");

    // R6 colour 15
    wcfg(mk(0,1,0,0,0,0,0,0,2'd0,0,4'h0));
    pix(4'h0, 3'd0, 4'hF, 3'd6, 4'h0, 3'd0, 0, "R6");
    wcfg(mk(0,1,0,0,0,1,0,0,2'd0,0,4'h0));
    pix(4'h0, 3'd0, 4'hF, 3'd6, 4'h0, 3'd0, 0, "R6");

    // R7 YS hold
    wcfg(mk(0,1,0,0,0,0,1,0,2'd0,0,4'h0));
    pix(4'h0, 3'd0, 4'hF, 3'd6, 4'h0, 3'd0, 1, "R7");
    pix(4'h0, 3'd0, 4'hE, 3'd6, 4'h0, 3'd0, 0, "R7");

    // R8 split mode
    wcfg(mk(0,1,1,0,0,0,1,1,2'd0,0,4'h0));
    pix(4'h0, 3'd0, 4'hF, 3'd6, 4'h2, 3'd1, 0, "R8");
    pix(4'h0, 3'd0, 4'h0, 3'd3, 4'h2, 3'd1, 0, "R8");

    // R9 graphics depth
    wcfg(mk(0,1,1,0,0,1,0,0,2'd1,0,4'h0));
    pix(4'h0, 3'd0, 4'hD, 3'd2, 4'h8, 3'd1, 0, "R9");
    wcfg(mk(0,1,1,0,0,1,0,0,2'd3,0,4'h0));
    pix(4'h0, 3'd0, 4'hE, 3'd2, 4'h8, 3'd1, 0, "R9");
    wcfg(mk(0,1,1,0,0,1,0,0,2'd2,0,4'h0));
    pix(4'h0, 3'd0, 4'h6, 3'd2, 4'h8, 3'd1, 0, "R9");

    // R10 background
    wcfg(mk(1,1,1,0,0,0,0,0,2'd0,1,4'h9));
    pix(4'h0, 3'd3, 4'h0, 3'd2, 4'h0, 3'd1, 2, "R10");
    wcfg(mk(1,1,1,0,0,0,0,0,2'd0,0,4'h9));
    pix(4'h0, 3'd3, 4'h0, 3'd2, 4'h0, 3'd1, 0, "R10");

    // random mix, R1 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 400; i++) begin
      logic [3:0] c[3];
      if (i % 16 == 0) wcfg(15'($urandom));
      for (int j = 0; j < 3; j++) begin
        case ($urandom % 4)
          0: c[j] = 4'h0;
          1: c[j] = 4'hF;
          default: c[j] = 4'($urandom);
        endcase
      end
      pix(c[0], PW'($urandom), c[1], PW'($urandom), c[2], PW'($urandom),
          int'($urandom % 3), "R1/R4 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule